// File: doc/BRIEF.md
# Audio Codec Link Input Frame Receiver

This block sits on the controller side of a serial audio codec link and takes apart the frames the codec sends back. It runs on the link bit clock. A rising edge on the frame sync line marks where a frame starts. Each frame is 256 bit periods long. It holds a 16-bit tag slot, then twelve 20-bit data slots, and every slot is sent most significant bit first. The first tag bit says whether the codec is operational. The next twelve tag bits say which data slots carry meaningful content.

The receiver samples the serial line and the sync line on the falling edge of the bit clock. All of its state moves on the rising edge. Once the tag slot has been received, it shows the codec-ready flag and the slot tags as plain status pins. For each tagged slot, it then hands out one beat on a valid/ready output carrying the slot number and the 20-bit word. The output port is a single register and the serial stream cannot be stalled. A beat therefore stays on the port, unchanged, until it is taken or until the next slot completes. A slot completes at most once every 20 bit clocks. The newer beat then replaces the older one, so a consumer that raises ready within 20 bit clocks of valid never loses a beat. If a sync edge arrives after the wrong number of bits, a sticky framing-error flag is set and the counters realign to the new frame.

Top module: `codec_link_rx`

## Requirements
- R1: While reset is asserted, codec_ready_o, slot_tags_o, frame_err_o and pld_valid_o are all 0, and reset clears a framing error seen earlier.
- R2: After reset, serial data produces no beat and no ready indication until the first rising edge of sync_i has been sampled.
- R3: The bit sampled on the first falling edge after the sync rise is the ready flag. The receiver presents it on codec_ready_o once the 16-bit tag slot has completed, and it holds that value until the next frame's tag slot completes.
- R4: Tag-slot bits 2 to 13 in arrival order are the tags for slots 1 to 12. slot_tags_o bit n-1 shows the tag for slot n, and slot_tags_o reads all zero while codec_ready_o is 0.
- R5: In a frame whose ready flag is 1, every slot n with its tag set yields exactly one beat. The beat carries pld_slot_o = n and pld_data_o equal to the slot's 20 bits, the first received bit being bit 19. Beats appear in ascending slot order.
- R6: Slots whose tag is 0, the tag slot itself, and every slot of a frame whose ready flag is 0 produce no beat.
- R7: While pld_valid_o is 1 and pld_ready_i is 0, the beat stays valid with slot and data unchanged. The only exception is a newer slot completing, which replaces the held beat. A beat is consumed on a rising edge where valid and ready are both 1.
- R8: A sync rise after any number of bits other than 256 sets frame_err_o, which stays set until reset. The following frame is decoded normally from its own first bit.
- R9: Bits beyond the 256th of an overlong frame produce no beat. Holding sync_i high does not restart the frame; only a 0-to-1 transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync; a 0-to-1 transition starts a frame |
| sdin_i | input | 1 | Serial input data from the codec |
| codec_ready_o | output | 1 | Ready flag of the last received tag slot |
| slot_tags_o | output | 12 | Slot tags, bit n-1 for slot n, zero when not ready |
| frame_err_o | output | 1 | Sticky wrong-frame-length flag |
| pld_valid_o | output | 1 | A slot beat is on offer |
| pld_ready_i | input | 1 | Consumer accepts the beat on this edge |
| pld_slot_o | output | 4 | Slot number 1 to 12 of the beat |
| pld_data_o | output | 20 | Slot payload |

## Verification
Frames carry directed payloads that sit on the slot edges: all ones, all zeros, and a word with only bit 19 and bit 0 set. A wrong bit count or a reversed bit order in any slot therefore shows up at once. Tag patterns of all set, none set, and a sparse mix separate per-slot gating from a global gate. A frame with its ready flag at 0 but every tag set checks that the ready flag suppresses both the beats and the tag pins. Random frames with random ready flags, tags and payloads are compared with a bench-built beat list. Short and overlong frames show that the error flag sets, that the error is sticky, and that the counters realign. A run of ones before any sync edge, and a held-off consumer across two tagged slots, tell apart the lock and overwrite rules.

// File: rtl/clr_pkg.sv
package clr_pkg;
  localparam int unsigned CLR_TAG_BITS  = 16;
  localparam int unsigned CLR_SLOT_BITS = 20;
  localparam int unsigned CLR_NUM_SLOTS = 12;

  function automatic int unsigned clr_frame_len(input int unsigned tag_bits,
                                                input int unsigned slot_bits,
                                                input int unsigned num_slots);
    return tag_bits + slot_bits * num_slots;
  endfunction

  function automatic int unsigned clr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clr_sampler.sv
module clr_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic sdin_i,
  output logic bit_o,
  output logic rise_o
);
  logic sd_fall;
  logic sy_fall;
  logic sy_prev;

  // line capture on the falling edge, midway through the bit period
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_fall <= 1'b0;
      sy_fall <= 1'b0;
    end else begin
      sd_fall <= sdin_i;
      sy_fall <= sync_i;
    end
  end

  // rising-edge history of sync for transition detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy_prev <= 1'b0;
    else        sy_prev <= sy_fall;
  end

  assign bit_o  = sd_fall;
  assign rise_o = sy_fall & ~sy_prev;
endmodule

// File: rtl/clr_counter.sv
module clr_counter #(
  parameter int unsigned TAG_BITS  = clr_pkg::CLR_TAG_BITS,
  parameter int unsigned SLOT_BITS = clr_pkg::CLR_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = clr_pkg::CLR_NUM_SLOTS,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             active_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             slot_end_o,
  output logic             locked_o,
  output logic             err_o
);
  localparam int unsigned FRAME_BITS = clr_pkg::clr_frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS);
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned POS_W      = $clog2(clr_pkg::clr_max(TAG_BITS, SLOT_BITS));

  logic [CNT_W-1:0] cnt;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] last_pos;
  logic             locked;
  logic             err;

  // the current bit's place: cnt counts bits of the frame, pos inside the slot
  assign last_pos   = (slot_o == '0) ? POS_W'(TAG_BITS - 1) : POS_W'(SLOT_BITS - 1);
  assign active_o   = locked && (cnt < CNT_W'(FRAME_BITS));
  assign slot_end_o = active_o && (pos == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pos    <= '0;
      slot_o <= '0;
      locked <= 1'b0;
      err    <= 1'b0;
    end else if (rise_i) begin
      // the bit sampled with the sync rise closes the old frame
      if (locked && (cnt != CNT_W'(FRAME_BITS - 1))) err <= 1'b1;
      locked <= 1'b1;
      cnt    <= '0;
      pos    <= '0;
      slot_o <= '0;
    end else if (active_o) begin
      cnt <= cnt + 1'b1;
      if (slot_end_o) begin
        pos    <= '0;
        slot_o <= slot_o + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign locked_o = locked;
  assign err_o    = err;

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));

  p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (slot_o <= IDX_W'(NUM_SLOTS)));
endmodule

// File: rtl/clr_unpack.sv
module clr_unpack #(
  parameter int unsigned TAG_BITS  = clr_pkg::CLR_TAG_BITS,
  parameter int unsigned SLOT_BITS = clr_pkg::CLR_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = clr_pkg::CLR_NUM_SLOTS,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_i,
  input  logic                 active_i,
  input  logic [IDX_W-1:0]     slot_i,
  input  logic                 slot_end_i,
  output logic                 ready_o,
  output logic [NUM_SLOTS-1:0] tags_o,
  output logic                 load_o,
  output logic [IDX_W-1:0]     load_slot_o,
  output logic [SLOT_BITS-1:0] load_data_o
);
  logic [SLOT_BITS-2:0] shreg;
  logic [SLOT_BITS-1:0] word;
  logic [NUM_SLOTS-1:0] tag_word;
  logic [NUM_SLOTS-1:0] tags_q;
  logic                 ready_q;
  logic                 tag_hit;

  // the word completed by the current bit, earliest bit in the top position
  assign word = {shreg, bit_i};

  // tag for slot k+1 sits one place below the ready flag per step
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_tag
    assign tag_word[k] = word[TAG_BITS - 2 - k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      ready_q <= 1'b0;
      tags_q  <= '0;
    end else if (active_i) begin
      shreg <= word[SLOT_BITS-2:0];
      if (slot_end_i && (slot_i == '0)) begin
        ready_q <= word[TAG_BITS-1];
        tags_q  <= tag_word;
      end
    end
  end

  always_comb begin
    tag_hit = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (slot_i == IDX_W'(k + 1)) tag_hit = tags_q[k];
    end
  end

  assign ready_o     = ready_q;
  assign tags_o      = ready_q ? tags_q : '0;
  assign load_o      = slot_end_i && (slot_i != '0) && ready_q && tag_hit;
  assign load_slot_o = slot_i;
  assign load_data_o = word;
endmodule

// File: rtl/clr_beat_port.sv
module clr_beat_port #(
  parameter int unsigned DATA_W    = clr_pkg::CLR_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = clr_pkg::CLR_NUM_SLOTS,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  load_slot_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  slot_o,
  output logic [DATA_W-1:0] data_o
);
  // a fresh slot always wins; otherwise hold until taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      slot_o  <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      slot_o  <= load_slot_i;
      data_o  <= load_data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(slot_o) && $stable(data_o)));

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !load_i) |=> !valid_o);

  p_slot_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> ((load_slot_i != '0) && (load_slot_i <= IDX_W'(NUM_SLOTS))));
endmodule

// File: rtl/codec_link_rx.sv
module codec_link_rx #(
  parameter int unsigned TAG_BITS  = clr_pkg::CLR_TAG_BITS,
  parameter int unsigned SLOT_BITS = clr_pkg::CLR_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = clr_pkg::CLR_NUM_SLOTS,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_i,
  input  logic                 sdin_i,
  output logic                 codec_ready_o,
  output logic [NUM_SLOTS-1:0] slot_tags_o,
  output logic                 frame_err_o,
  output logic                 pld_valid_o,
  input  logic                 pld_ready_i,
  output logic [IDX_W-1:0]     pld_slot_o,
  output logic [SLOT_BITS-1:0] pld_data_o
);
  logic                 s_bit;
  logic                 s_rise;
  logic                 c_active;
  logic [IDX_W-1:0]     c_slot;
  logic                 c_slot_end;
  logic                 c_locked;
  logic                 u_load;
  logic [IDX_W-1:0]     u_load_slot;
  logic [SLOT_BITS-1:0] u_load_data;

  clr_sampler u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .sdin_i (sdin_i),
    .bit_o  (s_bit),
    .rise_o (s_rise)
  );

  clr_counter #(
    .TAG_BITS  (TAG_BITS),
    .SLOT_BITS (SLOT_BITS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (s_rise),
    .active_o   (c_active),
    .slot_o     (c_slot),
    .slot_end_o (c_slot_end),
    .locked_o   (c_locked),
    .err_o      (frame_err_o)
  );

  clr_unpack #(
    .TAG_BITS  (TAG_BITS),
    .SLOT_BITS (SLOT_BITS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_unpack (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_i       (s_bit),
    .active_i    (c_active),
    .slot_i      (c_slot),
    .slot_end_i  (c_slot_end),
    .ready_o     (codec_ready_o),
    .tags_o      (slot_tags_o),
    .load_o      (u_load),
    .load_slot_o (u_load_slot),
    .load_data_o (u_load_data)
  );

  clr_beat_port #(
    .DATA_W    (SLOT_BITS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (u_load),
    .load_slot_i (u_load_slot),
    .load_data_i (u_load_data),
    .ready_i     (pld_ready_i),
    .valid_o     (pld_valid_o),
    .slot_o      (pld_slot_o),
    .data_o      (pld_data_o)
  );

  p_quiet_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !c_locked |-> (!pld_valid_o && !codec_ready_o));
endmodule

// File: tb/codec_link_rx_test.sv
module codec_link_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic        sdin_i = 1'b0;
  logic        pld_ready_i = 1'b1;
  logic        codec_ready_o;
  logic [11:0] slot_tags_o;
  logic        frame_err_o;
  logic        pld_valid_o;
  logic [3:0]  pld_slot_o;
  logic [19:0] pld_data_o;

  int checks = 0;
  int fails  = 0;
  logic [19:0] pay [1:12];
  logic [23:0] exp_q [$];
  logic [23:0] got_q [$];

  always #2 clk = ~clk;

  codec_link_rx uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_i        (sync_i),
    .sdin_i        (sdin_i),
    .codec_ready_o (codec_ready_o),
    .slot_tags_o   (slot_tags_o),
    .frame_err_o   (frame_err_o),
    .pld_valid_o   (pld_valid_o),
    .pld_ready_i   (pld_ready_i),
    .pld_slot_o    (pld_slot_o),
    .pld_data_o    (pld_data_o)
  );

  // record every accepted beat
  always @(negedge clk) begin
    if (rst_n && pld_valid_o && pld_ready_i) got_q.push_back({pld_slot_o, pld_data_o});
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive(input bit sd, input bit sy);
    @(posedge clk);
    #1;
    sdin_i = sd;
    sync_i = sy;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      sdin_i = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sync_i = 1'b0;
    sdin_i = 1'b0;
    pld_ready_i = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs held low in reset
    chk({codec_ready_o, slot_tags_o, frame_err_o, pld_valid_o} == '0, "R1 reset outputs",
        {codec_ready_o, slot_tags_o, frame_err_o, pld_valid_o}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic rand_pay();
    for (int k = 1; k <= 12; k++) pay[k] = 20'($urandom);
  endtask

  // drives 256+extra bits; sync rises on the final bit to open the next frame
  task automatic send_frame(input bit rdy, input logic [11:0] tg, input int extra, input bit bp_probe);
    logic [255:0] fv;
    fv = '0;
    fv[0] = rdy;
    for (int k = 1; k <= 12; k++) fv[k] = tg[k-1];
    for (int k = 1; k <= 12; k++)
      for (int j = 0; j < 20; j++) fv[16 + 20*(k-1) + (19-j)] = pay[k][j];
    for (int i = 0; i < 256 + extra; i++) begin
      bit b;
      b = (i < 256) ? fv[i] : 1'($urandom_range(0, 1));
      drive(b, (i < 15) || (i == 255 + extra));
      if (i == 20) begin
        chk(codec_ready_o == rdy, "R3 ready flag", 32'(codec_ready_o), 32'(rdy));
        chk(slot_tags_o == (rdy ? tg : 12'h000), "R4 tag pins", 32'(slot_tags_o), 32'(rdy ? tg : 12'h000));
      end
      if (bp_probe && i == 45) begin
        chk(pld_valid_o && pld_slot_o == 4'd1 && pld_data_o == pay[1], "R7 held beat",
            {pld_valid_o, 7'd0, pld_slot_o, pld_data_o}, {1'b1, 7'd0, 4'd1, pay[1]});
      end
      if (bp_probe && i == 70) begin
        chk(pld_valid_o && pld_slot_o == 4'd2 && pld_data_o == pay[2], "R7 overwrite",
            {pld_valid_o, 7'd0, pld_slot_o, pld_data_o}, {1'b1, 7'd0, 4'd2, pay[2]});
      end
    end
    if (rdy && !bp_probe)
      for (int k = 1; k <= 12; k++)
        if (tg[k-1]) exp_q.push_back({4'(k), pay[k]});
  endtask

  task automatic send_short(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, (i < 15) || (i == n - 1));
  endtask

  task automatic compare(input string req);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    exp_q.delete();
    got_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));

    // R1 and R2: reset state, then ones with no sync edge
    do_reset();
    for (int i = 0; i < 300; i++) drive(1'b1, 1'b0);
    settle(2);
    chk(codec_ready_o == 1'b0, "R2 no ready before sync", 32'(codec_ready_o), 0);
    chk(got_q.size() == 0, "R2 no beats before sync", got_q.size(), 0);

    // R5, R6, R3, R4: directed frames then random frames back to back
    drive(1'b0, 1'b1);
    pay[1] = 20'h80001; pay[2] = 20'hFFFFF; pay[3] = 20'h00000;
    for (int k = 4; k <= 12; k++) pay[k] = 20'h5A3C0 ^ 20'(k * 20'h11111);
    send_frame(1'b1, 12'hFFF, 0, 1'b0);
    send_frame(1'b0, 12'hFFF, 0, 1'b0);   // R6: not ready, no beats
    send_frame(1'b1, 12'h000, 0, 1'b0);   // R6: no tags, no beats
    rand_pay();
    send_frame(1'b1, 12'hA53, 0, 1'b0);
    for (int f = 0; f < 20; f++) begin
      rand_pay();
      send_frame(($urandom_range(0, 7) != 0), 12'($urandom), 0, 1'b0);
    end
    settle(4);
    compare("R5 R6 beat stream");
    chk(frame_err_o == 1'b0, "R8 no error on exact frames", 32'(frame_err_o), 0);

    // R7: consumer held off across two tagged slots
    do_reset();
    drive(1'b0, 1'b1);
    pld_ready_i = 1'b0;
    rand_pay();
    send_frame(1'b1, 12'h003, 0, 1'b1);
    settle(3);
    chk(pld_valid_o && pld_slot_o == 4'd2 && pld_data_o == pay[2], "R7 held after frame",
        {pld_valid_o, 7'd0, pld_slot_o, pld_data_o}, {1'b1, 7'd0, 4'd2, pay[2]});
    pld_ready_i = 1'b1;
    exp_q.push_back({4'd2, pay[2]});
    settle(1);
    chk(pld_valid_o == 1'b0, "R7 consumed", 32'(pld_valid_o), 0);
    settle(2);
    compare("R7 single beat delivered");

    // R8: short frame sets error, next frame realigned
    do_reset();
    drive(1'b0, 1'b1);
    rand_pay();
    send_frame(1'b1, 12'($urandom), 0, 1'b0);
    chk(frame_err_o == 1'b0, "R8 clear before short", 32'(frame_err_o), 0);
    send_short(100);
    rand_pay();
    send_frame(1'b1, 12'hFFF, 0, 1'b0);
    rand_pay();
    send_frame(1'b1, 12'h5A5, 0, 1'b0);
    settle(4);
    chk(frame_err_o == 1'b1, "R8 sticky error after short", 32'(frame_err_o), 1);
    compare("R8 realigned beats");

    // R9: overlong frame, extra bits ignored, error flagged
    do_reset();
    drive(1'b0, 1'b1);
    rand_pay();
    send_frame(1'b1, 12'h0F0, 0, 1'b0);
    chk(frame_err_o == 1'b0, "R8 clear before long", 32'(frame_err_o), 0);
    rand_pay();
    send_frame(1'b1, 12'hFFF, 40, 1'b0);
    rand_pay();
    send_frame(1'b1, 12'h801, 0, 1'b0);
    settle(4);
    chk(frame_err_o == 1'b1, "R9 long frame flagged", 32'(frame_err_o), 1);
    compare("R9 no beats from extra bits");

    // R1: reset in the middle of activity
    do_reset();
    drive(1'b0, 1'b1);
    pld_ready_i = 1'b0;
    rand_pay();
    send_frame(1'b1, 12'h800, 0, 1'b0);
    settle(1);
    chk(pld_valid_o && codec_ready_o, "R5 slot 12 beat pending", {pld_valid_o, codec_ready_o}, 2'b11);
    rst_n = 1'b0;
    #1;
    chk({codec_ready_o, slot_tags_o, frame_err_o, pld_valid_o} == '0, "R1 async reset clears",
        {codec_ready_o, slot_tags_o, frame_err_o, pld_valid_o}, 0);
    settle(2);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule